// File: doc/BRIEF.md
# Pipelined Host Port for Display RAM

This block connects a byte-wide parallel host bus to a display RAM held inside the block. The RAM is arranged as pages of columns. The host selects the chip, then issues single-strobe accesses. Data-mode writes and reads move display bytes. Command-mode writes set the column and page address. Every transfer passes through one holding register that sits between the host bus and the RAM. As a result, the RAM side runs one access behind the host and no wait state is ever inserted.

A write lands in the holding register and reaches the RAM on the next clock. A read drives the bus from the holding register and, at the same time, starts a RAM read at the current address that refills the register for the next read. Because of this, the first read after an address change or after a write returns stale data, and software must issue one dummy read first. The column advances after every data access, and this lets the host stream through a page.

Top module: `dispram_host_port`

## Requirements
- R1: The port is selected only while `sel_lo_n` is 0 and `sel_hi` is 1. While it is deselected, `bus_oe` stays 0, and strobes change neither the column, the page nor the holding register.
- R2: A selected read with `is_data`=1 sets `bus_oe` to 1 and drives `bus_out` with the holding register. A selected read with `is_data`=0 leaves `bus_oe` at 0 and changes nothing.
- R3: A selected data write loads `bus_in` into the holding register with no wait state. The byte is stored to the RAM at the address current during the write in the following clock.
- R4: Each data read loads the holding register from the RAM byte at the address current during that read. The next data read returns this byte.
- R5: Every address-set command clears the holding register to 0x00, so the first data read after it returns 0x00.
- R6: The first data read after a data write returns the byte just written, not RAM data at the current column.
- R7: The column advances by one after each data read and each data write, and wraps from COLS-1 (131 by default) to 0. The page does not change.
- R8: A command write decodes `bus_in[7:4]` as follows. 0x0 replaces column bits [3:0] with `bus_in[3:0]`. 0x1 replaces column bits [7:4] with `bus_in[3:0]`. 0xB loads the page with `bus_in[3:0]` modulo PAGES. After each column write, a column above COLS-1 becomes COLS-1. Every other code has no effect.
- R9: Each access strobe lasts one clock and is followed by at least one idle clock. This is the minimum cycle time, and under it the single RAM port never has to serve a commit and a read in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel_lo_n | input | 1 | Select, active low |
| sel_hi | input | 1 | Select, active high |
| is_data | input | 1 | 1 = display data, 0 = command |
| rd_strobe_n | input | 1 | Read strobe, active low |
| wr_strobe_n | input | 1 | Write strobe, active low |
| bus_in | input | 8 | Host data toward the block |
| bus_out | output | 8 | Host data from the block |
| bus_oe | output | 1 | Drive enable for the bus (0 = high impedance) |

## Verification
A corrupted holding register shows on the very next data read. A late or misaddressed commit appears one dummy read later, as the wrong byte on the second read after an address set. A column pointer that steps or wraps wrongly shifts every later readback by one position, so the first pattern byte read after the fault already disagrees. A select or command-decode fault shows as the bus being driven when it should float, or as a stale or cleared byte on the next data read.

// File: rtl/dhp_pkg.sv
package dhp_pkg;

  localparam int DATA_W = 8;
  localparam int COL_W  = 8;

  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_COL_LO,
    CMD_COL_HI,
    CMD_PAGE
  } cmd_kind_e;

  // Decode the upper nibble of a command byte.
  function automatic cmd_kind_e cmd_classify(input logic [7:0] b);
    case (b[7:4])
      4'h0:    return CMD_COL_LO;
      4'h1:    return CMD_COL_HI;
      4'hB:    return CMD_PAGE;
      default: return CMD_NONE;
    endcase
  endfunction

  // Saturate a column value at the last column.
  function automatic logic [COL_W-1:0] col_limit(input logic [COL_W-1:0] v,
                                                 input logic [COL_W-1:0] last);
    return (v > last) ? last : v;
  endfunction

  // Column after one data access, wrapping past the last column.
  function automatic logic [COL_W-1:0] col_advance(input logic [COL_W-1:0] c,
                                                   input logic [COL_W-1:0] last);
    return (c >= last) ? '0 : c + 1'b1;
  endfunction

  // Linear RAM index of a page/column pair.
  function automatic int flat_index(input int page, input int col, input int cols);
    return page * cols + col;
  endfunction

endpackage

// File: rtl/dhp_decode.sv
module dhp_decode
  import dhp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_lo_n,
  input  logic             sel_hi,
  input  logic             is_data,
  input  logic             rd_strobe_n,
  input  logic             wr_strobe_n,
  input  logic [DATA_W-1:0] bus_in,
  output logic             selected,
  output logic             ev_wr,
  output logic             ev_rd,
  output cmd_kind_e        cmd_kind,
  output logic [3:0]       cmd_arg,
  output logic             bus_drive
);

  logic rd_act, wr_act;

  always_comb begin
    selected  = !sel_lo_n && sel_hi;
    rd_act    = selected && !rd_strobe_n && wr_strobe_n;
    wr_act    = selected && !wr_strobe_n && rd_strobe_n;
    ev_wr     = wr_act && is_data;
    ev_rd     = rd_act && is_data;
    cmd_kind  = (wr_act && !is_data) ? cmd_classify(bus_in) : CMD_NONE;
    cmd_arg   = bus_in[3:0];
    bus_drive = ev_rd;
  end

  // R9: one strobe clock, then at least one idle clock
  assert_min_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_act || wr_act) |=> !(rd_act || wr_act));

endmodule

// File: rtl/dhp_addr.sv
module dhp_addr
  import dhp_pkg::*;
#(
  parameter int COLS  = 132,
  parameter int PAGES = 8,
  localparam int PW   = $clog2(PAGES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_kind_e        cmd_kind,
  input  logic [3:0]       cmd_arg,
  input  logic             step,
  output logic [COL_W-1:0] col,
  output logic [PW-1:0]    page,
  output logic             ev_wrap
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [COL_W-1:0] col_nx;
  logic [PW-1:0]    page_nx;

  always_comb begin
    col_nx  = col;
    page_nx = page;
    ev_wrap = step && (col == LAST_COL);
    case (cmd_kind)
      CMD_COL_LO: col_nx  = col_limit({col[7:4], cmd_arg}, LAST_COL);
      CMD_COL_HI: col_nx  = col_limit({cmd_arg, col[3:0]}, LAST_COL);
      CMD_PAGE:   page_nx = PW'(cmd_arg);
      default:    ;
    endcase
    if (step) col_nx = col_advance(col, LAST_COL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col  <= '0;
      page <= '0;
    end else begin
      col  <= col_nx;
      page <= page_nx;
    end
  end

  assert_col_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    col <= LAST_COL);
  assert_col_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wrap |=> (col == '0));
  assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ev_wrap) |=> (col == $past(col) + 1'b1) && $stable(page));

endmodule

// File: rtl/dhp_holder.sv
module dhp_holder
  import dhp_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_wr,
  input  logic              ev_rd,
  input  logic              ev_clr,
  input  logic [DATA_W-1:0] bus_in,
  input  logic [DATA_W-1:0] ram_q,
  input  logic [AW-1:0]     addr_now,
  output logic [DATA_W-1:0] hold,
  output logic              commit,
  output logic [AW-1:0]     commit_addr,
  output logic              fill
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold        <= '0;
      commit      <= 1'b0;
      commit_addr <= '0;
      fill        <= 1'b0;
    end else begin
      commit <= ev_wr;
      fill   <= ev_rd;
      if (ev_wr) commit_addr <= addr_now;
      if (ev_wr)       hold <= bus_in;
      else if (fill)   hold <= ram_q;
      else if (ev_clr) hold <= '0;
    end
  end

endmodule

// File: rtl/dhp_ram.sv
module dhp_ram
  import dhp_pkg::*;
#(
  parameter int DEPTH = 1056,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              re,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] wd,
  output logic [DATA_W-1:0] rq
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
    if (re) rq <= mem[addr];
  end

  // R9: the spacing rule leaves the single port free for each use
  assert_one_port_use_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && re));

endmodule

// File: rtl/dispram_host_port.sv
module dispram_host_port
  import dhp_pkg::*;
#(
  parameter int COLS  = 132,
  parameter int PAGES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_lo_n,
  input  logic        sel_hi,
  input  logic        is_data,
  input  logic        rd_strobe_n,
  input  logic        wr_strobe_n,
  input  logic [7:0]  bus_in,
  output logic [7:0]  bus_out,
  output logic        bus_oe
);

  localparam int DEPTH = COLS * PAGES;
  localparam int AW    = $clog2(DEPTH);
  localparam int PW    = $clog2(PAGES);

  logic             selected, ev_wr, ev_rd, ev_wrap, ev_clr;
  cmd_kind_e        cmd_kind;
  logic [3:0]       cmd_arg;
  logic [COL_W-1:0] col;
  logic [PW-1:0]    page;
  logic [DATA_W-1:0] hold, ram_q;
  logic             commit, fill;
  logic [AW-1:0]    commit_addr, addr_now, ram_addr;

  dhp_decode u_dec (
    .clk, .rst_n, .sel_lo_n, .sel_hi, .is_data, .rd_strobe_n, .wr_strobe_n,
    .bus_in, .selected, .ev_wr, .ev_rd, .cmd_kind, .cmd_arg, .bus_drive(bus_oe)
  );

  dhp_addr #(.COLS(COLS), .PAGES(PAGES)) u_addr (
    .clk, .rst_n, .cmd_kind, .cmd_arg, .step(ev_wr || ev_rd),
    .col, .page, .ev_wrap
  );

  always_comb begin
    ev_clr   = (cmd_kind != CMD_NONE);
    addr_now = AW'(flat_index(int'(page), int'(col), COLS));
    ram_addr = commit ? commit_addr : addr_now;
    bus_out  = hold;
  end

  dhp_holder #(.AW(AW)) u_hold (
    .clk, .rst_n, .ev_wr, .ev_rd, .ev_clr, .bus_in, .ram_q, .addr_now,
    .hold, .commit, .commit_addr, .fill
  );

  dhp_ram #(.DEPTH(DEPTH)) u_ram (
    .clk, .rst_n, .we(commit), .re(ev_rd), .addr(ram_addr), .wd(hold), .rq(ram_q)
  );

  // R1: a deselected port keeps its address
  assert_unselected_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !selected |=> $stable(col) && $stable(page));
  // R3: a write is committed on the very next clock
  assert_commit_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr |=> commit && (hold == $past(bus_in)));
  // R5: an address-set command empties the holder
  assert_clear_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_clr && !fill) |=> (hold == '0));
  // R2: the bus is only driven during a data read
  assert_drive_only_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> selected && is_data && !rd_strobe_n);

endmodule

// File: tb/sim_dispram_host_port.sv
module sim_dispram_host_port;

  localparam int COLS  = 132;
  localparam int PAGES = 8;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sel_lo_n = 1'b1, sel_hi = 1'b0, is_data = 1'b0;
  logic       rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0] bus_in = '0;
  logic [7:0] bus_out;
  logic       bus_oe;

  int checks = 0, fails = 0;
  bit done = 0;

  // Reference model state
  logic [7:0] mem_m [PAGES*COLS];
  bit         known_m [PAGES*COLS];
  logic [8:0] hold_m;  // bit 8 = value known
  int         col_m = 0, page_m = 0;

  logic [8:0] exp_q [$];
  string      tag_q [$];

  always #2.5ns clk = ~clk;

  dispram_host_port #(.COLS(COLS), .PAGES(PAGES)) u0 (
    .clk, .rst_n, .sel_lo_n, .sel_hi, .is_data, .rd_strobe_n(rd_n),
    .wr_strobe_n(wr_n), .bus_in, .bus_out, .bus_oe
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every selected data read
  always @(negedge clk) begin
    if (rst_n && !sel_lo_n && sel_hi && is_data && !rd_n && wr_n) begin
      if (exp_q.size() == 0) check(0, "R4 unexpected read", bus_out, 0);
      else begin
        logic [8:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (e[8]) check(bus_oe && (bus_out === e[7:0]), t, {bus_oe, bus_out}, {1'b1, e[7:0]});
      end
    end
  end

  task automatic strobe(input bit lo_n, input bit hi, input bit d, input bit rd,
                        input bit wr, input logic [7:0] b, input bit chk_float,
                        input string req);
    @(posedge clk); #1ns;
    sel_lo_n = lo_n; sel_hi = hi; is_data = d; rd_n = !rd; wr_n = !wr; bus_in = b;
    if (chk_float) begin
      @(negedge clk);
      check(bus_oe == 1'b0, req, bus_oe, 0);
    end
    @(posedge clk); #1ns;
    rd_n = 1'b1; wr_n = 1'b1; sel_lo_n = 1'b0; sel_hi = 1'b1;
  endtask

  function automatic int idx();
    return page_m * COLS + col_m;
  endfunction

  function automatic void step_col();
    col_m = (col_m == COLS - 1) ? 0 : col_m + 1;
  endfunction

  task automatic wr_data(input logic [7:0] b);
    mem_m[idx()] = b; known_m[idx()] = 1; hold_m = {1'b1, b}; step_col();
    strobe(0, 1, 1, 0, 1, b, 0, "");
  endtask

  task automatic rd_data(input string req);
    exp_q.push_back(hold_m); tag_q.push_back(req);
    hold_m = {known_m[idx()], mem_m[idx()]}; step_col();
    strobe(0, 1, 1, 1, 0, 8'h00, 0, "");
  endtask

  task automatic cmd(input logic [7:0] b);
    int v;
    case (b[7:4])
      4'h0: begin v = (col_m & 8'hF0) | b[3:0]; col_m = (v > COLS-1) ? COLS-1 : v; hold_m = 9'h100; end
      4'h1: begin v = (col_m & 8'h0F) | (b[3:0] << 4); col_m = (v > COLS-1) ? COLS-1 : v; hold_m = 9'h100; end
      4'hB: begin page_m = b[3:0] % PAGES; hold_m = 9'h100; end
      default: ;
    endcase
    strobe(0, 1, 0, 0, 1, b, 0, "");
  endtask

  task automatic set_addr(input int p, input int c);
    cmd(8'h10 | 8'((c >> 4) & 15));
    cmd(8'h00 | 8'(c & 15));
    cmd(8'hB0 | 8'(p));
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 37 + 5);
  endfunction

  initial begin
    #(200000 * 5ns);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < PAGES*COLS; i++) begin known_m[i] = 0; mem_m[i] = '0; end
    hold_m = 9'h100;
    repeat (3) @(posedge clk);
    #1ns rst_n = 1'b1;
    @(negedge clk);
    check(bus_oe == 1'b0, "R1 reset bus floats", bus_oe, 0);

    // R3 write a pattern, R6 read without dummy gives last written byte
    set_addr(0, 0);
    for (int i = 0; i < 8; i++) wr_data(pat(i));
    rd_data("R6 stale read after write");

    // R5 first read after address set is 0x00, R4 then pattern in order
    set_addr(0, 0);
    rd_data("R5 dummy read returns cleared holder");
    for (int i = 0; i < 8; i++) rd_data("R4 pattern readback");

    // R7 wrap from last column to 0
    set_addr(3, COLS - 2);
    wr_data(8'hA1); wr_data(8'hB2); wr_data(8'hC3);
    set_addr(3, COLS - 2);
    rd_data("R5 dummy");
    rd_data("R7 col 130"); rd_data("R7 col 131"); rd_data("R7 wrapped to col 0");

    // R8 column clamp and page modulo
    set_addr(2, 8'h9F);
    wr_data(8'h5A);
    set_addr(2, COLS - 1);
    rd_data("R5 dummy"); rd_data("R8 clamped column");
    cmd(8'h10); cmd(8'h05); cmd(8'hB9);
    wr_data(8'h3C);
    set_addr(1, 5);
    rd_data("R5 dummy"); rd_data("R8 page modulo");

    // R8 unknown command leaves holder and column alone
    set_addr(0, 0);
    rd_data("R5 dummy");
    cmd(8'h70);
    rd_data("R8 ignored command keeps holder");
    rd_data("R8 ignored command keeps column");

    // R1 deselected strobes have no effect
    strobe(1, 1, 1, 0, 1, 8'hEE, 0, "");
    strobe(0, 0, 0, 0, 1, 8'hB5, 0, "");
    strobe(1, 1, 1, 1, 0, 8'h00, 1, "R1 bus floats when deselected");
    strobe(0, 0, 1, 1, 0, 8'h00, 1, "R1 bus floats when deselected");
    rd_data("R1 holder unchanged by deselected strobes");
    rd_data("R1 column unchanged by deselected strobes");

    // R2 command-mode read floats the bus and changes nothing
    strobe(0, 1, 0, 1, 0, 8'h00, 1, "R2 command read floats bus");
    rd_data("R2 command read had no effect");
    rd_data("R4 continued readback");

    repeat (4) @(posedge clk);
    check(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule